// File: doc/BRIEF.md
# Kick-Address System Watchdog

The block guards a system against stalled software. It counts ticks of a 32.768 kHz timebase, delivered as a one-cycle enable on the fast system clock. Software services it by writing to a dedicated address; the bus decoder turns that write into a kick strobe for this block. If no kick arrives before the tick count reaches its limit, the block emits a one-cycle system reset request. The default limit is 65536 ticks, which is exactly two seconds.

Two conditions stop the watchdog and hold its count at zero. One is a disable bit from the system configuration register. The other is a flag showing that the device is in power-down mode. When either condition clears, a full new timeout period starts. A system reset also clears the count, and this includes the reset that the watchdog's own request causes. Reset stretching and address decoding are handled by neighbouring logic.

Top module: `kick_watchdog`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `rst_req_o` is 0 and the count starts from zero, so the first request needs a full `TIMEOUT_TICKS` ticks.
- R2: While the block is enabled and no kick or system reset arrives, the cycle after the edge that samples the `TIMEOUT_TICKS`-th tick has `rst_req_o` = 1.
- R3: `rst_req_o` stays high for exactly one cycle. The count then restarts from zero, so the next request needs another `TIMEOUT_TICKS` ticks.
- R4: A cycle with `kick_i` = 1 resets the count to zero. A tick sampled in the same cycle is not counted.
- R5: A kick sampled together with the tick that would reach the limit suppresses the request.
- R6: While `wdog_off_i` = 1, the count is held at zero and no request is issued. After the bit clears, a full period is needed.
- R7: While `pwr_down_i` = 1, the count is held at zero and no request is issued. After the flag clears, a full period is needed.
- R8: `sys_rst_i` = 1 clears the count and blocks the request, whatever the tick and kick inputs are.
- R9: Cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 32.768 kHz |
| kick_i | input | 1 | Strobe from a write to the watchdog service address |
| wdog_off_i | input | 1 | Configuration bit that disables the watchdog |
| pwr_down_i | input | 1 | High while in power-down mode |
| sys_rst_i | input | 1 | Synchronous system reset, clears the count |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Every input acts at the next rising edge, and the only output is registered. As a result, `rst_req_o` reflects the inputs sampled at one edge just after that edge. The count is internal, so it shows only through when the next request arrives. The bench drives inputs at the falling edge and advances its own reference count at the same rising edge the design uses. It compares `rst_req_o` one time unit after that edge on every cycle. A reduced `TIMEOUT_TICKS` keeps several full timeouts, and the kicks, disables and resets placed exactly on the terminal tick, within the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Next count value; clear and wrap both return to zero
  function automatic logic [31:0] wdt_step(input logic [31:0] cnt,
                                           input logic adv,
                                           input logic clr,
                                           input logic wrap);
    if (clr || wrap) return 32'd0;
    if (adv)         return cnt + 32'd1;
    return cnt;
  endfunction

  // Terminal test: the advancing tick completes the period
  function automatic logic wdt_last(input logic [31:0] cnt,
                                    input logic adv,
                                    input logic [31:0] limit);
    return adv && (cnt == limit - 32'd1);
  endfunction
endpackage

// File: rtl/wdt_gate.sv
module wdt_gate (
  input  logic tick_i,
  input  logic kick_i,
  input  logic wdog_off_i,
  input  logic pwr_down_i,
  input  logic sys_rst_i,
  output logic active_o,
  output logic clear_o,
  output logic adv_o
);
  // Running only when neither disabled nor powered down
  assign active_o = !wdog_off_i && !pwr_down_i;
  // Kick, system reset or an idle watchdog all force the count to zero
  assign clear_o  = sys_rst_i || kick_i || !active_o;
  assign adv_o    = tick_i && !clear_o;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned TIMEOUT_TICKS = 65536,
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_ext;
  logic [31:0]      cnt_nxt;

  assign cnt_ext  = 32'(cnt_q);
  assign expire_o = wdt_last(cnt_ext, adv_i, TIMEOUT_TICKS);
  assign cnt_nxt  = wdt_step(cnt_ext, adv_i, clear_i, expire_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  output logic req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= expire_i;
  end
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int unsigned TIMEOUT_TICKS = 65536,
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic kick_i,
  input  logic wdog_off_i,
  input  logic pwr_down_i,
  input  logic sys_rst_i,
  output logic rst_req_o
);
  // Named internal events, brought out for the checker
  logic             active_w;
  logic             clear_w;
  logic             adv_w;
  logic             expire_w;
  logic [CNT_W-1:0] cnt_w;

  wdt_gate u_gate (
    .tick_i     (tick_i),
    .kick_i     (kick_i),
    .wdog_off_i (wdog_off_i),
    .pwr_down_i (pwr_down_i),
    .sys_rst_i  (sys_rst_i),
    .active_o   (active_w),
    .clear_o    (clear_w),
    .adv_o      (adv_w)
  );

  wdt_count #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_w),
    .adv_i    (adv_w),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  wdt_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire_w),
    .req_o    (rst_req_o)
  );
endmodule

// File: rtl/kick_watchdog_chk.sv
module kick_watchdog_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             kick_i,
  input logic             wdog_off_i,
  input logic             pwr_down_i,
  input logic             sys_rst_i,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt
);
  // R2
  req_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(tick_i));
  // R3
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R4
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt == '0) && !rst_req_o);
  // R6
  off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_off_i |=> (cnt == '0) && !rst_req_o);
  // R7
  pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (cnt == '0) && !rst_req_o);
  // R8
  sysrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> (cnt == '0) && !rst_req_o);
  // R9
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !kick_i && !sys_rst_i && !wdog_off_i && !pwr_down_i) |=> $stable(cnt));
endmodule

bind kick_watchdog kick_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .kick_i     (kick_i),
  .wdog_off_i (wdog_off_i),
  .pwr_down_i (pwr_down_i),
  .sys_rst_i  (sys_rst_i),
  .rst_req_o  (rst_req_o),
  .cnt        (cnt_w)
);

// File: tb/sim_kick_watchdog.sv
`timescale 1ns/1ps
module sim_kick_watchdog;
  localparam int unsigned T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, kick = 1'b0, off = 1'b0, pd = 1'b0, srst = 1'b0;
  logic req;

  int checks = 0;
  int fails  = 0;
  int mcnt   = 0;   // reference count
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  kick_watchdog #(.TIMEOUT_TICKS(T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick),
    .wdog_off_i(off), .pwr_down_i(pd), .sys_rst_i(srst), .rst_req_o(req)
  );

  // Request due from inputs sampled at one edge
  function automatic bit ref_fire(int c, bit t, bit k, bit d, bit p, bit s);
    return t && !k && !d && !p && !s && (c == int'(T) - 1);
  endfunction

  function automatic int ref_next(int c, bit t, bit k, bit d, bit p, bit s);
    if (k || d || p || s) return 0;
    if (!t) return c;
    return (c + 1 == int'(T)) ? 0 : c + 1;
  endfunction

  task automatic check(string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rst_req_o=%b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit k, bit d, bit p, bit s, string tag = "");
    bit e;
    string rq;
    @(negedge clk);
    tick = t; kick = k; off = d; pd = p; srst = s;
    e = ref_fire(mcnt, t, k, d, p, s);
    if (tag != "")  rq = tag;
    else if (e)     rq = "R2";
    else if (s)     rq = "R8";
    else if (d)     rq = "R6";
    else if (p)     rq = "R7";
    else if (k)     rq = "R4";
    else if (!t)    rq = "R9";
    else            rq = "R3";
    mcnt = ref_next(mcnt, t, k, d, p, s);
    @(posedge clk);
    #1;
    check(rq, req, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 check("R1", req, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    // R1: full period from reset, then R2 pulse on the T-th tick
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R2");
    // R3: single cycle, then another full period with gaps (R9)
    step(0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < int'(T) - 1; i++) begin
      step(1, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, "R9");
    end
    step(1, 0, 0, 0, 0, "R3");
    // R5: kick on terminal tick suppresses
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, "R5");
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    // R6: disable on terminal tick, then full period needed
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, "R6");
    step(1, 0, 1, 0, 0, "R6");
    for (int i = 0; i < int'(T); i++) step(1, 0, 0, 0, 0, "R6");
    // R7: power-down likewise
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, "R7");
    for (int i = 0; i < int'(T); i++) step(1, 0, 0, 0, 0, "R7");
    // R8: system reset with tick and kick on terminal tick
    for (int i = 0; i < int'(T) - 1; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, "R8");
    for (int i = 0; i < int'(T); i++) step(1, 0, 0, 0, 0, "R8");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit rt, rk, rd, rp, rs;
      rt = ($urandom_range(0, 2) != 0);
      rk = ($urandom_range(0, 59) == 0);
      rd = ($urandom_range(0, 79) == 0);
      rp = ($urandom_range(0, 89) == 0);
      rs = ($urandom_range(0, 99) == 0);
      step(rt, rk, rd, rp, rs);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule